// File: doc/BRIEF.md
# Raster Timing Generator with Horizontal Phase Offset

This block produces the horizontal and vertical timing for an interlace-style standard-definition panel from a single pixel clock. A clock counter steps across each line and a line counter steps down each frame. From these two counts the block decodes the internal horizontal and vertical sync pulses, the blanking signal, an active-video enable and the pixel and line coordinates inside the active window.

Four configuration words can be written at any time:
- the frame size, as a line total and a clock total;
- the start position of the active window, relative to the internal syncs;
- the sync pulse widths;
- a horizontal offset.

The offset moves the active window and the blanking interval left or right in 2-pixel steps. It does not change the start-position setting, and it does not move the sync pulses. A new offset is taken up only at the end of the current line, so no line is ever drawn with two phases. The shift is meant to stay smaller than one line.

Top module: `raster_phase_timer`

## Requirements
- R1: After reset the block uses these values: 858 clocks per line, 525 lines per frame, active start at line 40 and clock 131, Hsync width 64 clocks, Vsync width 3 lines, and offset 0. The clock and line counts both start at 0.
- R2: While `run` is high, the clock count advances once per clock and returns to 0 after reaching the clock total minus 1. The line count advances each time the clock count wraps, and returns to 0 after reaching the line total minus 1.
- R3: While `run` is low, both counts hold, and so do all timing outputs.
- R4: `hsync` is high exactly while the clock count is below the Hsync width. `vsync` is high exactly while the line count is below the Vsync width. Neither depends on the offset.
- R5: The pixel shift is the offset value divided by two. The window start is (start clock − shift) modulo the clock total. `active` is high when both of these hold:
  - the line count is at least the start line;
  - (clock count − window start) modulo the clock total is below (clock total − start clock).
- R6: `blank` is the inverse of `active` on every cycle.
- R7: While `active` is high, `pix_x` equals (clock count − window start) modulo the clock total, and `pix_y` equals the line count minus the start line. Both are 0 while blanked.
- R8: An offset write stores only data bits 10:2. Bits 1:0 are forced to zero, and bits 31:11 are ignored.
- R9: A written offset takes effect on the first clock of the next line. The line already in progress keeps the previous shift.
- R10: A write with `cfg_we` high selects its target with `cfg_sel`:
  - 0 selects the frame size: line total in bits 31:16, clock total in bits 15:0.
  - 1 selects the start position: line in bits 31:16, clock in bits 15:0.
  - 2 selects the sync widths: Vsync lines in bits 31:16, Hsync clocks in bits 15:0.
  - 3 selects the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| hsync | output | 1 | Internal horizontal sync |
| vsync | output | 1 | Internal vertical sync |
| blank | output | 1 | Blanking, high outside the active window |
| active | output | 1 | Active-video enable |
| pix_x | output | 16 | Pixel column inside the active window |
| pix_y | output | 16 | Line row inside the active window |

## Verification
The assertions check the following on every cycle:
- the counters wrap at the line end;
- both counts hold while `run` is low;
- the low offset bits stay zero;
- the applied shift changes only at a line boundary;
- `pix_x` never reaches the active width.

Some behaviours can only be shown by the bench scenarios, because they need frame-level arithmetic:
- where the shifted window actually lands;
- that the syncs ignore the offset;
- the reset defaults over forty-odd full lines;
- the deferred uptake of a mid-line offset write.

The bench compares each output against a model that computes these quantities directly from the requirements.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    SEL_SIZE   = 2'd0,
    SEL_START  = 2'd1,
    SEL_SYNC   = 2'd2,
    SEL_OFFSET = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/raster_cfg.sv
module raster_cfg #(
  parameter int CW         = 16,
  parameter int OFFW       = 11,
  parameter int HTOT_DEF   = 858,
  parameter int VTOT_DEF   = 525,
  parameter int HSTART_DEF = 131,
  parameter int VSTART_DEF = 40,
  parameter int HSW_DEF    = 64,
  parameter int VSW_DEF    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [2*CW-1:0] wdata,
  input  logic            line_end,
  output logic [CW-1:0]   htot,
  output logic [CW-1:0]   vtot,
  output logic [CW-1:0]   hst,
  output logic [CW-1:0]   vst,
  output logic [CW-1:0]   hsw,
  output logic [CW-1:0]   vsw,
  output logic [OFFW-2:0] shift
);
  import raster_pkg::*;

  logic [CW-1:0]   htot_q, htot_d, vtot_q, vtot_d;
  logic [CW-1:0]   hst_q, hst_d, vst_q, vst_d;
  logic [CW-1:0]   hsw_q, hsw_d, vsw_q, vsw_d;
  logic [OFFW-1:0] off_q, off_d, act_q, act_d;

  always_comb begin
    htot_d = htot_q; vtot_d = vtot_q;
    hst_d  = hst_q;  vst_d  = vst_q;
    hsw_d  = hsw_q;  vsw_d  = vsw_q;
    off_d  = off_q;
    if (we) begin
      unique case (cfg_sel_e'(sel))
        SEL_SIZE:   begin vtot_d = wdata[2*CW-1:CW]; htot_d = wdata[CW-1:0]; end
        SEL_START:  begin vst_d  = wdata[2*CW-1:CW]; hst_d  = wdata[CW-1:0]; end
        SEL_SYNC:   begin vsw_d  = wdata[2*CW-1:CW]; hsw_d  = wdata[CW-1:0]; end
        SEL_OFFSET: off_d = {wdata[OFFW-1:2], 2'b00};
        default: ;
      endcase
    end
    // R9: the applied offset follows the written one only at a line end
    act_d = line_end ? off_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htot_q <= CW'(HTOT_DEF);
      vtot_q <= CW'(VTOT_DEF);
      hst_q  <= CW'(HSTART_DEF);
      vst_q  <= CW'(VSTART_DEF);
      hsw_q  <= CW'(HSW_DEF);
      vsw_q  <= CW'(VSW_DEF);
      off_q  <= '0;
      act_q  <= '0;
    end else begin
      htot_q <= htot_d; vtot_q <= vtot_d;
      hst_q  <= hst_d;  vst_q  <= vst_d;
      hsw_q  <= hsw_d;  vsw_q  <= vsw_d;
      off_q  <= off_d;
      act_q  <= act_d;
    end
  end

  assign htot  = htot_q;
  assign vtot  = vtot_q;
  assign hst   = hst_q;
  assign vst   = vst_q;
  assign hsw   = hsw_q;
  assign vsw   = vsw_q;
  assign shift = act_q[OFFW-1:1];

  assert_offmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_q[1:0] == 2'b00);
  assert_shift_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(act_q));
endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          line_end
);
  logic [CW-1:0] h_q, h_d, v_q, v_d;
  logic          h_wrap, v_wrap;

  assign h_wrap   = (h_q >= htot - CW'(1));
  assign v_wrap   = (v_q >= vtot - CW'(1));
  assign line_end = run && h_wrap;

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (run) begin
      h_d = h_wrap ? '0 : h_q + CW'(1);
      if (h_wrap) v_d = v_wrap ? '0 : v_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign hcnt = h_q;
  assign vcnt = v_q;

  assert_hwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_q == htot - CW'(1)) |=> h_q == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(h_q) && $stable(v_q)));
endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int CW   = 16,
  parameter int SHW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  hcnt,
  input  logic [CW-1:0]  vcnt,
  input  logic [CW-1:0]  htot,
  input  logic [CW-1:0]  hst,
  input  logic [CW-1:0]  vst,
  input  logic [CW-1:0]  hsw,
  input  logic [CW-1:0]  vsw,
  input  logic [SHW-1:0] shift,
  output logic           hsync,
  output logic           vsync,
  output logic           active,
  output logic [CW-1:0]  pix_x,
  output logic [CW-1:0]  pix_y
);
  logic [CW:0]   ws_raw, dx_raw;
  logic [CW-1:0] ws, dx, width;
  logic          in_v, in_h;

  always_comb begin
    ws_raw = {1'b0, hst} - {1'b0, CW'(shift)};
    ws     = ws_raw[CW] ? ws_raw[CW-1:0] + htot : ws_raw[CW-1:0];
    dx_raw = {1'b0, hcnt} - {1'b0, ws};
    dx     = dx_raw[CW] ? dx_raw[CW-1:0] + htot : dx_raw[CW-1:0];
    width  = htot - hst;
    in_v   = (vcnt >= vst);
    in_h   = (dx < width);
    active = in_v && in_h;
    pix_x  = active ? dx : '0;
    pix_y  = active ? vcnt - vst : '0;
    hsync  = (hcnt < hsw);
    vsync  = (vcnt < vsw);
  end

  assert_px_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pix_x < width));
endmodule

// File: rtl/raster_phase_timer.sv
module raster_phase_timer #(
  parameter int CW         = 16,
  parameter int OFFW       = 11,
  parameter int HTOT_DEF   = 858,
  parameter int VTOT_DEF   = 525,
  parameter int HSTART_DEF = 131,
  parameter int VSTART_DEF = 40,
  parameter int HSW_DEF    = 64,
  parameter int VSW_DEF    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [2*CW-1:0] cfg_wdata,
  output logic            hsync,
  output logic            vsync,
  output logic            blank,
  output logic            active,
  output logic [CW-1:0]   pix_x,
  output logic [CW-1:0]   pix_y
);
  localparam int SHW = OFFW - 1;

  logic [CW-1:0]  htot, vtot, hst, vst, hsw, vsw, hcnt, vcnt;
  logic [SHW-1:0] shift;
  logic           line_end, act_w;

  raster_cfg #(
    .CW(CW), .OFFW(OFFW), .HTOT_DEF(HTOT_DEF), .VTOT_DEF(VTOT_DEF),
    .HSTART_DEF(HSTART_DEF), .VSTART_DEF(VSTART_DEF),
    .HSW_DEF(HSW_DEF), .VSW_DEF(VSW_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .line_end(line_end), .htot(htot), .vtot(vtot), .hst(hst), .vst(vst),
    .hsw(hsw), .vsw(vsw), .shift(shift)
  );

  raster_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .htot(htot), .vtot(vtot),
    .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end)
  );

  raster_window #(.CW(CW), .SHW(SHW)) u_win (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .htot(htot),
    .hst(hst), .vst(vst), .hsw(hsw), .vsw(vsw), .shift(shift),
    .hsync(hsync), .vsync(vsync), .active(act_w), .pix_x(pix_x), .pix_y(pix_y)
  );

  assign active = act_w;
  assign blank  = ~act_w;
endmodule

// File: tb/raster_phase_timer_tb.sv
module raster_phase_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        hsync, vsync, blank, active;
  logic [15:0] pix_x, pix_y;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  raster_phase_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .blank(blank),
    .active(active), .pix_x(pix_x), .pix_y(pix_y)
  );

  // Reference model, built from R1, R2, R8, R9, R10
  int m_h, m_v, m_htot, m_vtot, m_hst, m_vst, m_hsw, m_vsw, m_off, m_act;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h <= 0; m_v <= 0; m_htot <= 858; m_vtot <= 525; m_hst <= 131;
      m_vst <= 40; m_hsw <= 64; m_vsw <= 3; m_off <= 0; m_act <= 0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin m_vtot <= int'(cfg_wdata[31:16]); m_htot <= int'(cfg_wdata[15:0]); end
          2'd1: begin m_vst  <= int'(cfg_wdata[31:16]); m_hst  <= int'(cfg_wdata[15:0]); end
          2'd2: begin m_vsw  <= int'(cfg_wdata[31:16]); m_hsw  <= int'(cfg_wdata[15:0]); end
          default: m_off <= int'(cfg_wdata[10:0]) & 32'h7FC;
        endcase
      end
      if (run) begin
        if (m_h >= m_htot - 1) begin
          m_h <= 0;
          m_act <= m_off;
          m_v <= (m_v >= m_vtot - 1) ? 0 : m_v + 1;
        end else m_h <= m_h + 1;
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (h=%0d v=%0d)", req, what, got, exp, m_h, m_v);
    end
  endtask

  task automatic check_all();
    int sh, ws, dx, ea;
    sh = m_act / 2;
    ws = (m_hst >= sh) ? m_hst - sh : m_hst + m_htot - sh;
    dx = (m_h >= ws) ? m_h - ws : m_h + m_htot - ws;
    ea = (m_v >= m_vst && dx < m_htot - m_hst) ? 1 : 0;
    chk("R4", "hsync", int'(hsync), (m_h < m_hsw) ? 1 : 0);
    chk("R4", "vsync", int'(vsync), (m_v < m_vsw) ? 1 : 0);
    chk("R5", "active", int'(active), ea);
    chk("R6", "blank", int'(blank), 1 - ea);
    chk("R7", "pix_x", int'(pix_x), ea ? dx : 0);
    chk("R7", "pix_y", int'(pix_y), ea ? m_v - m_vst : 0);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      cfg_we = 1'b0;
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);  // R10 select encoding
    @(negedge clk);
    check_all();
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
  endtask

  task automatic pause_check(int n);  // R3
    logic hs0, vs0, ac0;
    logic [15:0] px0, py0;
    @(negedge clk);
    run = 1'b0;
    hs0 = hsync; vs0 = vsync; ac0 = active; px0 = pix_x; py0 = pix_y;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R3", "hold hsync", int'(hsync), int'(hs0));
      chk("R3", "hold vsync", int'(vsync), int'(vs0));
      chk("R3", "hold active", int'(active), int'(ac0));
      chk("R3", "hold pix_x", int'(pix_x), int'(px0));
      chk("R3", "hold pix_y", int'(pix_y), int'(py0));
    end
    run = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset hsync", int'(hsync), 1);
    chk("R1", "reset vsync", int'(vsync), 1);
    chk("R1", "reset active", int'(active), 0);
    chk("R1", "reset pix_x", int'(pix_x), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    // R1/R2: default geometry through the first active lines
    cycles(858 * 42 + 50);
    // R2 small frame: 6 lines of 20 clocks, start line 2 clock 5, syncs 3 clocks / 1 line
    wr(2'd0, 32'h0006_0014);
    wr(2'd1, 32'h0002_0005);
    wr(2'd2, 32'h0001_0003);
    cycles(300);
    // R5 sweep of every legal offset whose shift fits in the line
    for (int k = 0; k < 10; k++) begin
      wr(2'd3, 32'(k * 4));
      cycles(7 + k);           // R9 write lands mid-line; old shift holds
      pause_check(4);
      cycles(240);
    end
    // R8: ignored upper bits and masked low bits leave value 0x10
    wr(2'd3, 32'hFFFF_F813);
    cycles(260);
    // R9: write then change again within the same line
    wr(2'd3, 32'h0000_0024);
    wr(2'd3, 32'h0000_0008);
    cycles(260);
    // R10: start and sync reprogramming
    wr(2'd1, 32'h0003_0000);
    wr(2'd2, 32'h0002_000A);
    cycles(260);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule